// File: doc/BRIEF.md
# Four-Level Page Table Walker

This block turns a 48-bit virtual address into a physical address. It does this by walking a four-level radix tree of translation tables held in memory. A requester hands it a virtual address, the base of the top-level table and the kind of access: read, write or instruction fetch. The walker then reads one 8-byte table entry per level over a simple read request and response port. It stops when it reaches a leaf entry. It returns the physical address, a page-size code and a fault flag in a single-cycle completion pulse.

Each table holds 512 entries of 8 bytes, so one table fills one 4 KB page. A leaf can appear at three depths. An entry with its size bit set at the second level maps a 1 GB page, and one at the third level maps a 2 MB page. An entry at the fourth level always maps a 4 KB page. A walk therefore takes two, three or four memory reads, and the untranslated offset is 30, 21 or 12 bits wide. A missing entry, a misplaced size bit or an access that the visited entries do not permit ends the walk with a fault.

The walker serves one translation at a time. It is meant to sit behind a translation cache and run only on a miss.

Top module: `ptw_walker`

## Requirements
- R1: `req_ready` is high only while the walker is idle. A request accepted on a clock edge makes `busy` high and `req_ready` low from that edge on. `busy` stays high up to and including the single cycle in which `done` is high. After that cycle `done`, `busy` and `req_ready` return to 0, 0 and 1.
- R2: The read at each level is at address table_base + index × 8. The indices are virtual address bits [47:39], [38:30], [29:21] and [20:12], taken in that order from the top level down. The first table base is `req_root` with bits [11:0] cleared.
- R3: A present non-leaf entry gives the next table base as entry bits [51:12] followed by twelve zero bits.
- R4: When no size bit is set along the way, the walk makes exactly 4 reads. The result is {entry[51:12], vaddr[11:0]} from the fourth-level entry, and `done_size` is 0.
- R5: When entry bit 7 is set in a present third-level entry, the walk ends after 3 reads. The result is {entry[51:21], vaddr[20:0]}, and `done_size` is 1.
- R6: When entry bit 7 is set in a present second-level entry, the walk ends after 2 reads. The result is {entry[51:30], vaddr[29:0]}, and `done_size` is 2. Entry bits [29:12] of such a leaf have no effect on the result.
- R7: An entry with bit 0 clear is not present. It ends the walk with a fault, and no further reads are made.
- R8: Entry bit 7 set in a present first-level or fourth-level entry is reserved. It ends the walk with a fault at that entry.
- R9: A write request (`req_write` = 1) faults at the leaf unless entry bit 1 is set in every entry visited. A read request ignores bit 1.
- R10: A fetch request (`req_exec` = 1) faults at the leaf if entry bit 63 is set in any entry visited. A read request ignores bit 63.
- R11: At most one memory read is outstanding. `mem_req_valid` and `mem_req_addr` stay unchanged until `mem_req_ready` is high, and the next read is not issued before the response arrives.
- R12: A faulting completion reports `done_paddr` = 0 and `done_size` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker can accept a request |
| req_vaddr | input | 48 | Virtual address to translate |
| req_root | input | 52 | Top-level table base (low 12 bits ignored) |
| req_write | input | 1 | Access is a write |
| req_exec | input | 1 | Access is an instruction fetch |
| mem_req_valid | output | 1 | Entry read request |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 52 | Byte address of the 8-byte entry |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_data | input | 64 | Returned table entry |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle completion pulse |
| done_paddr | output | 52 | Translated physical address |
| done_size | output | 2 | Page size: 0 = 4 KB, 1 = 2 MB, 2 = 1 GB |
| done_fault | output | 1 | Walk ended in a fault |

## Verification
The same virtual address is walked through one table chain that is edited from scenario to scenario. It is walked as a 4 KB page with a non-zero offset, as a 2 MB page and as a 1 GB page that has stray bits below its alignment. These three cases tell apart the three leaf depths, the offset widths and the frame masking, and the read count separates an early stop from a full walk. Faulting chains place the missing entry, the reserved size bit and the permission denial at both the first and the last level, so an early abort can be told from a late one. Read and write/fetch requests are run against the same entries to show that permissions act only on the access kinds they govern. A stalled memory port checks that the read request is held unchanged.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

   typedef enum logic [1:0] {
      PTW_IDLE,
      PTW_REQ,
      PTW_WAIT,
      PTW_DONE
   } ptw_state_e;

   localparam int PTE_PRESENT_BIT = 0;
   localparam int PTE_WRITE_BIT   = 1;
   localparam int PTE_LEAF_BIT    = 7;
   localparam int PTE_NOEXEC_BIT  = 63;

endpackage

// File: rtl/ptw_index_sel.sv
module ptw_index_sel #(
   parameter int VA_W        = 48,
   parameter int PA_W        = 52,
   parameter int LEVELS      = 4,
   parameter int IDX_W       = 9,
   parameter int OFF_W       = 12,
   parameter int ENTRY_BYTES = 8,
   localparam int LVL_W      = (LEVELS > 1) ? $clog2(LEVELS) : 1,
   localparam int SH_W       = $clog2(ENTRY_BYTES)
) (
   input  logic [VA_W-1:0]  vaddr,
   input  logic [LVL_W-1:0] lvl,
   input  logic [PA_W-1:0]  table_base,
   output logic [PA_W-1:0]  entry_addr
);

   logic [IDX_W-1:0] idx_by_lvl [LEVELS];
   logic [IDX_W-1:0] idx_sel;

   for (genvar l = 0; l < LEVELS; l++) begin : g_idx
      localparam int TOP = OFF_W + IDX_W * (LEVELS - l) - 1;
      assign idx_by_lvl[l] = vaddr[TOP -: IDX_W];
   end

   always_comb begin
      idx_sel = '0;
      for (int l = 0; l < LEVELS; l++) begin
         if (lvl == LVL_W'(l)) idx_sel = idx_by_lvl[l];
      end
   end

   assign entry_addr = table_base + {{(PA_W - IDX_W - SH_W){1'b0}}, idx_sel, {SH_W{1'b0}}};

endmodule

// File: rtl/ptw_entry_eval.sv
module ptw_entry_eval
   import ptw_pkg::*;
#(
   parameter int LEVELS       = 4,
   parameter int ENTRY_W      = 64,
   parameter bit ALLOW_HUGE   = 1'b1,
   parameter int HUGE_MIN_LVL = 1,
   localparam int LVL_W       = (LEVELS > 1) ? $clog2(LEVELS) : 1
) (
   input  logic [ENTRY_W-1:0] entry,
   input  logic [LVL_W-1:0]   lvl,
   input  logic               want_write,
   input  logic               want_exec,
   input  logic               w_ok_in,
   input  logic               x_ok_in,
   output logic               w_ok_out,
   output logic               x_ok_out,
   output logic               leaf,
   output logic               fault,
   output logic [LVL_W-1:0]   size_code
);

   logic present, size_bit, last_lvl, huge_here, ends_here, perm_bad, ps_bad;

   assign present  = entry[PTE_PRESENT_BIT];
   assign size_bit = entry[PTE_LEAF_BIT];
   assign last_lvl = (lvl == LVL_W'(LEVELS - 1));

   if (ALLOW_HUGE) begin : g_huge
      assign huge_here = (lvl >= LVL_W'(HUGE_MIN_LVL)) && !last_lvl;
   end else begin : g_no_huge
      assign huge_here = 1'b0;
   end

   assign w_ok_out  = w_ok_in & entry[PTE_WRITE_BIT];
   assign x_ok_out  = x_ok_in & ~entry[PTE_NOEXEC_BIT];
   assign ends_here = last_lvl || size_bit;
   assign ps_bad    = size_bit && !huge_here;
   assign perm_bad  = ends_here && ((want_write && !w_ok_out) || (want_exec && !x_ok_out));
   assign fault     = !present || ps_bad || perm_bad;
   assign leaf      = !fault && ends_here;
   assign size_code = LVL_W'(LEVELS - 1) - lvl;

endmodule

// File: rtl/ptw_compose.sv
module ptw_compose #(
   parameter int VA_W    = 48,
   parameter int PA_W    = 52,
   parameter int LEVELS  = 4,
   parameter int IDX_W   = 9,
   parameter int OFF_W   = 12,
   parameter int ENTRY_W = 64,
   localparam int LVL_W  = (LEVELS > 1) ? $clog2(LEVELS) : 1
) (
   input  logic [ENTRY_W-1:0] entry,
   input  logic [VA_W-1:0]    vaddr,
   input  logic [LVL_W-1:0]   lvl,
   output logic [PA_W-1:0]    leaf_paddr,
   output logic [PA_W-1:0]    next_base
);

   logic [PA_W-1:0] pa_by_lvl [LEVELS];

   for (genvar l = 0; l < LEVELS; l++) begin : g_pa
      localparam int OW = OFF_W + IDX_W * (LEVELS - 1 - l);
      assign pa_by_lvl[l] = {entry[PA_W-1:OW], vaddr[OW-1:0]};
   end

   always_comb begin
      leaf_paddr = '0;
      for (int l = 0; l < LEVELS; l++) begin
         if (lvl == LVL_W'(l)) leaf_paddr = pa_by_lvl[l];
      end
   end

   assign next_base = {entry[PA_W-1:OFF_W], {OFF_W{1'b0}}};

endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
   import ptw_pkg::*;
#(
   parameter int VA_W         = 48,
   parameter int PA_W         = 52,
   parameter int LEVELS       = 4,
   parameter int IDX_W        = 9,
   parameter int OFF_W        = 12,
   parameter int ENTRY_BYTES  = 8,
   parameter bit ALLOW_HUGE   = 1'b1,
   parameter int HUGE_MIN_LVL = 1,
   localparam int ENTRY_W     = ENTRY_BYTES * 8,
   localparam int LVL_W       = (LEVELS > 1) ? $clog2(LEVELS) : 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               req_valid,
   output logic               req_ready,
   input  logic [VA_W-1:0]    req_vaddr,
   input  logic [PA_W-1:0]    req_root,
   input  logic               req_write,
   input  logic               req_exec,
   output logic               mem_req_valid,
   input  logic               mem_req_ready,
   output logic [PA_W-1:0]    mem_req_addr,
   input  logic               mem_rsp_valid,
   input  logic [ENTRY_W-1:0] mem_rsp_data,
   output logic               busy,
   output logic               done,
   output logic [PA_W-1:0]    done_paddr,
   output logic [LVL_W-1:0]   done_size,
   output logic               done_fault
);

   if (VA_W != OFF_W + LEVELS * IDX_W) begin : g_chk_va
      $error("VA_W must equal OFF_W + LEVELS*IDX_W");
   end
   if (OFF_W + IDX_W * (LEVELS - 1) >= PA_W) begin : g_chk_pa
      $error("PA_W too narrow for the largest page");
   end
   if (PA_W > PTE_NOEXEC_BIT || ENTRY_W <= PTE_NOEXEC_BIT) begin : g_chk_entry
      $error("entry layout does not fit the address width");
   end
   if ((1 << IDX_W) * ENTRY_BYTES != (1 << OFF_W)) begin : g_chk_tbl
      $error("one table must fill exactly one base page");
   end

   ptw_state_e       state_q;
   logic [VA_W-1:0]  va_q;
   logic [PA_W-1:0]  base_q;
   logic [LVL_W-1:0] lvl_q;
   logic             wr_q, ex_q, w_ok_q, x_ok_q;
   logic [PA_W-1:0]  res_pa_q;
   logic [LVL_W-1:0] res_sz_q;
   logic             res_fault_q;

   logic             ev_w_ok, ev_x_ok, ev_leaf, ev_fault;
   logic [LVL_W-1:0] ev_size;
   logic [PA_W-1:0]  leaf_pa, nxt_base;

   ptw_index_sel #(
      .VA_W(VA_W), .PA_W(PA_W), .LEVELS(LEVELS), .IDX_W(IDX_W),
      .OFF_W(OFF_W), .ENTRY_BYTES(ENTRY_BYTES)
   ) u_index (
      .vaddr(va_q), .lvl(lvl_q), .table_base(base_q), .entry_addr(mem_req_addr)
   );

   ptw_entry_eval #(
      .LEVELS(LEVELS), .ENTRY_W(ENTRY_W), .ALLOW_HUGE(ALLOW_HUGE),
      .HUGE_MIN_LVL(HUGE_MIN_LVL)
   ) u_eval (
      .entry(mem_rsp_data), .lvl(lvl_q), .want_write(wr_q), .want_exec(ex_q),
      .w_ok_in(w_ok_q), .x_ok_in(x_ok_q), .w_ok_out(ev_w_ok), .x_ok_out(ev_x_ok),
      .leaf(ev_leaf), .fault(ev_fault), .size_code(ev_size)
   );

   ptw_compose #(
      .VA_W(VA_W), .PA_W(PA_W), .LEVELS(LEVELS), .IDX_W(IDX_W),
      .OFF_W(OFF_W), .ENTRY_W(ENTRY_W)
   ) u_compose (
      .entry(mem_rsp_data), .vaddr(va_q), .lvl(lvl_q),
      .leaf_paddr(leaf_pa), .next_base(nxt_base)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q     <= PTW_IDLE;
         va_q        <= '0;
         base_q      <= '0;
         lvl_q       <= '0;
         wr_q        <= 1'b0;
         ex_q        <= 1'b0;
         w_ok_q      <= 1'b1;
         x_ok_q      <= 1'b1;
         res_pa_q    <= '0;
         res_sz_q    <= '0;
         res_fault_q <= 1'b0;
      end else begin
         unique case (state_q)
            PTW_IDLE: begin
               if (req_valid) begin
                  va_q    <= req_vaddr;
                  base_q  <= {req_root[PA_W-1:OFF_W], {OFF_W{1'b0}}};
                  lvl_q   <= '0;
                  wr_q    <= req_write;
                  ex_q    <= req_exec;
                  w_ok_q  <= 1'b1;
                  x_ok_q  <= 1'b1;
                  state_q <= PTW_REQ;
               end
            end
            PTW_REQ: begin
               if (mem_req_ready) state_q <= PTW_WAIT;
            end
            PTW_WAIT: begin
               if (mem_rsp_valid) begin
                  if (ev_fault) begin
                     res_fault_q <= 1'b1;
                     res_pa_q    <= '0;
                     res_sz_q    <= '0;
                     state_q     <= PTW_DONE;
                  end else if (ev_leaf) begin
                     res_fault_q <= 1'b0;
                     res_pa_q    <= leaf_pa;
                     res_sz_q    <= ev_size;
                     state_q     <= PTW_DONE;
                  end else begin
                     base_q  <= nxt_base;
                     lvl_q   <= lvl_q + 1'b1;
                     w_ok_q  <= ev_w_ok;
                     x_ok_q  <= ev_x_ok;
                     state_q <= PTW_REQ;
                  end
               end
            end
            PTW_DONE: state_q <= PTW_IDLE;
            default:  state_q <= PTW_IDLE;
         endcase
      end
   end

   assign req_ready     = (state_q == PTW_IDLE);
   assign busy          = (state_q != PTW_IDLE);
   assign mem_req_valid = (state_q == PTW_REQ);
   assign done          = (state_q == PTW_DONE);
   assign done_paddr    = res_pa_q;
   assign done_size     = res_sz_q;
   assign done_fault    = res_fault_q;

   // R1: acceptance moves the walker out of idle on the next edge
   a_r1_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && req_ready |=> busy && !req_ready);

   // R1: completion is a single-cycle pulse, then idle
   a_r1_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done && req_ready);

   // R11: an unaccepted read is held unchanged
   a_r11_hold_req: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

   // R11: no back-to-back reads without a response in between
   a_r11_one_out: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid && mem_req_ready |=> !mem_req_valid);

   // R2: every entry read is aligned to the entry size
   a_r2_aligned: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid |-> mem_req_addr[$clog2(ENTRY_BYTES)-1:0] == '0);

   // R4: the base-page offset is carried through on every successful walk
   a_r4_offset: assert property (@(posedge clk) disable iff (!rst_n)
      done && !done_fault |-> done_paddr[OFF_W-1:0] == va_q[OFF_W-1:0]);

   // R12: faulting completions carry no address or size
   a_r12_fault_zero: assert property (@(posedge clk) disable iff (!rst_n)
      done && done_fault |-> done_paddr == '0 && done_size == '0);

endmodule

// File: tb/ptw_walker_tb.sv
`timescale 1ns/1ps
module ptw_walker_tb;

   localparam logic [63:0] P  = 64'h1;
   localparam logic [63:0] W  = 64'h2;
   localparam logic [63:0] PS = 64'h80;
   localparam logic [63:0] NX = 64'h8000_0000_0000_0000;
   localparam logic [51:0] ROOT = 52'h1A3000;
   localparam logic [51:0] A0 = 52'h1A37F0;
   localparam logic [51:0] A1 = 52'h3F5950;
   localparam logic [51:0] A2 = 52'h7A2CF0;
   localparam logic [51:0] A3 = 52'h1B80E8;
   localparam logic [47:0] VA = 48'h7F4A_B3C1_D000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [47:0] req_vaddr = '0;
   logic [51:0] req_root = '0;
   logic        req_write = 1'b0;
   logic        req_exec = 1'b0;
   logic        mem_req_valid;
   logic        mem_req_ready = 1'b1;
   logic [51:0] mem_req_addr;
   logic        mem_rsp_valid;
   logic [63:0] mem_rsp_data;
   logic        busy, done, done_fault;
   logic [51:0] done_paddr;
   logic [1:0]  done_size;

   int vectors = 0;
   int miscompares = 0;
   int rd_cnt = 0;
   logic [51:0] first_addr;
   logic [51:0] mem_a [4];
   logic [63:0] mem_d [4];

   always #4 clk = ~clk;

   ptw_walker u_dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_vaddr(req_vaddr), .req_root(req_root), .req_write(req_write),
      .req_exec(req_exec), .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
      .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
      .mem_rsp_data(mem_rsp_data), .busy(busy), .done(done),
      .done_paddr(done_paddr), .done_size(done_size), .done_fault(done_fault)
   );

   function automatic logic [63:0] lookup(logic [51:0] a);
      logic [63:0] d = '0;
      for (int i = 0; i < 4; i++) if (mem_a[i] == a) d = mem_d[i];
      return d;
   endfunction

   // memory responder: sees the same ready value the walker samples
   initial begin
      logic [51:0] a;
      mem_rsp_valid = 1'b0;
      mem_rsp_data  = '0;
      forever begin
         @(negedge clk);
         mem_rsp_valid = 1'b0;
         if (mem_req_valid && mem_req_ready) begin
            a = mem_req_addr;
            if (rd_cnt == 0) first_addr = a;
            rd_cnt++;
            @(negedge clk);
            mem_rsp_valid = 1'b1;
            mem_rsp_data  = lookup(a);
         end
      end
   end

   task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      vectors++;
      if (!ok) begin
         miscompares++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic chain(input logic [63:0] e0, input logic [63:0] e1,
                        input logic [63:0] e2, input logic [63:0] e3);
      mem_a[0] = A0; mem_d[0] = e0;
      mem_a[1] = A1; mem_d[1] = e1;
      mem_a[2] = A2; mem_d[2] = e2;
      mem_a[3] = A3; mem_d[3] = e3;
   endtask

   task automatic walk(input string tag, input logic [47:0] va, input bit wr, input bit ex,
                       input int stall, input bit exp_fault, input logic [51:0] exp_pa,
                       input logic [1:0] exp_sz, input int exp_reads);
      int cyc;
      if (stall > 0) begin
         @(posedge clk); #1 mem_req_ready = 1'b0;
      end
      @(negedge clk);
      rd_cnt = 0;
      req_valid = 1'b1; req_vaddr = va; req_root = ROOT | 52'hABC;
      req_write = wr; req_exec = ex;
      @(negedge clk);
      req_valid = 1'b0;
      chk(busy && !req_ready, {tag, " R1 busy after accept"}, {busy, req_ready}, 2'b10);
      if (stall > 0) begin
         for (int i = 0; i < stall; i++) begin
            chk(mem_req_valid && mem_req_addr == A0 && rd_cnt == 0,
                {tag, " R11 read held"}, mem_req_addr, A0);
            @(negedge clk);
         end
         @(posedge clk); #1 mem_req_ready = 1'b1;
      end
      cyc = 0;
      while (!done && cyc < 200) begin
         if (req_ready) chk(1'b0, {tag, " R1 ready during walk"}, 1, 0);
         @(negedge clk);
         cyc++;
      end
      chk(done, {tag, " R1 done seen"}, done, 1);
      chk(done_fault == exp_fault, {tag, " fault R7 R8 R9 R10"}, done_fault, exp_fault);
      chk(done_paddr == exp_pa, {tag, " paddr R4 R5 R6 R12"}, done_paddr, exp_pa);
      chk(done_size == exp_sz, {tag, " size R4 R5 R6 R12"}, done_size, exp_sz);
      chk(rd_cnt == exp_reads, {tag, " read count R4 R5 R6 R7"}, rd_cnt, exp_reads);
      chk(first_addr == A0, {tag, " R2 first entry address"}, first_addr, A0);
      @(negedge clk);
      chk(!done && !busy && req_ready, {tag, " R1 back to idle"}, {done, busy, req_ready}, 3'b001);
   endtask

   task automatic t_reset();
      chk(req_ready && !busy && !done && !mem_req_valid, "reset R1",
          {req_ready, busy, done, mem_req_valid}, 4'b1000);
   endtask

   task automatic t_base_page();
      chain(64'h3F5000 | P | W, 64'h7A2000 | P | W, 64'h1B8000 | P | W, 64'hC40000 | P | W);
      walk("4k R2 R3 R4", VA | 48'hABC, 1'b0, 1'b0, 0, 1'b0, 52'hC40ABC, 2'd0, 4);
   endtask

   task automatic t_mid_page();
      chain(64'h3F5000 | P, 64'h7A2000 | P, 64'hA00000 | P | PS, 64'h0);
      walk("2m R5", VA, 1'b0, 1'b0, 0, 1'b0, 52'hA1D000, 2'd1, 3);
   endtask

   task automatic t_big_page();
      chain(64'h3F5000 | P, 64'h8000_0000 | 64'h1000_0000 | 64'h5000 | P | PS, 64'h0, 64'h0);
      walk("1g R6", VA, 1'b0, 1'b0, 0, 1'b0, 52'hB3C1D000, 2'd2, 2);
   endtask

   task automatic t_missing();
      chain(64'h3F5000, 64'h7A2000 | P, 64'h1B8000 | P, 64'hC40000 | P);
      walk("absent top R7", VA, 1'b0, 1'b0, 0, 1'b1, 52'h0, 2'd0, 1);
      chain(64'h3F5000 | P, 64'h7A2000 | P, 64'h1B8000 | P, 64'hC40000);
      walk("absent leaf R7", VA, 1'b0, 1'b0, 0, 1'b1, 52'h0, 2'd0, 4);
   endtask

   task automatic t_reserved();
      chain(64'h3F5000 | P | PS, 64'h7A2000 | P, 64'h1B8000 | P, 64'hC40000 | P);
      walk("ps top R8", VA, 1'b0, 1'b0, 0, 1'b1, 52'h0, 2'd0, 1);
      chain(64'h3F5000 | P, 64'h7A2000 | P, 64'h1B8000 | P, 64'hC40000 | P | PS);
      walk("ps leaf R8", VA, 1'b0, 1'b0, 0, 1'b1, 52'h0, 2'd0, 4);
   endtask

   task automatic t_write_perm();
      chain(64'h3F5000 | P | W, 64'h7A2000 | P, 64'h1B8000 | P | W, 64'hC40000 | P | W);
      walk("write denied R9", VA, 1'b1, 1'b0, 0, 1'b1, 52'h0, 2'd0, 4);
      walk("read ignores W R9", VA, 1'b0, 1'b0, 0, 1'b0, 52'hC40000, 2'd0, 4);
      chain(64'h3F5000 | P | W, 64'h7A2000 | P | W, 64'h1B8000 | P | W, 64'hC40000 | P | W);
      walk("write allowed R9", VA, 1'b1, 1'b0, 0, 1'b0, 52'hC40000, 2'd0, 4);
   endtask

   task automatic t_exec_perm();
      chain(64'h3F5000 | P | NX, 64'h7A2000 | P, 64'hA00000 | P | PS, 64'h0);
      walk("fetch denied R10", VA, 1'b0, 1'b1, 0, 1'b1, 52'h0, 2'd0, 3);
      walk("read ignores NX R10", VA, 1'b0, 1'b0, 0, 1'b0, 52'hA1D000, 2'd1, 3);
      chain(64'h3F5000 | P, 64'h7A2000 | P, 64'hA00000 | P | PS, 64'h0);
      walk("fetch allowed R10", VA, 1'b0, 1'b1, 0, 1'b0, 52'hA1D000, 2'd1, 3);
   endtask

   task automatic t_stall();
      chain(64'h3F5000 | P, 64'h8000_0000 | P | PS, 64'h0, 64'h0);
      walk("stall R11", VA | 48'h123, 1'b0, 1'b0, 3, 1'b0, 52'hB3C1D123, 2'd2, 2);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_base_page();
      t_mid_page();
      t_big_page();
      t_missing();
      t_reserved();
      t_write_perm();
      t_exec_perm();
      t_stall();
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

   initial begin
      #(8 * 150000);
      vectors++;
      miscompares++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

endmodule